// File: doc/BRIEF.md
# Circular Debug Trace Capture Buffer

The block records one of four 128-bit debug trace buses into a circular on-chip store. While capture runs, it writes one entry on every clock from the selected bus and advances the write position, which wraps at the end of the store. A fill flag tells the block whether the store has wrapped, so it always knows which entry is the oldest. Capture stops, starts and clears through a command register. A configuration register picks the bus to record.

Software reads a stopped trace through two 64-bit data registers. One returns the upper half of each entry and the other returns the lower half. Each register has its own read position. On a stop command both positions are set to the oldest entry, and each read moves that register's position on by one entry. While capture is running, the reads return no entry data. The lower-half register then returns a running flag, so software can tell that a dump taken at that time is invalid.

The register port uses a single-cycle request strobe, a write enable, a 3-bit word address and 64-bit write data. Read data is registered. Bit numbers below are vector indices (bit 63 is the most significant bit of a word).

Top module: `trace_buf`

## Requirements
- R1: A write to the command register (address 0) acts on the bits set to one: bit 63 starts capture, bit 62 stops capture and bit 61 clears the pointers. When start and stop are set together, stop wins and capture stays stopped. The command register reads as zero.
- R2: The configuration register (address 1) holds the bus select in bits 49:48. Bus k is `trace_bus_i[k*128 +: 128]`. The field reads back in place, all other bits read zero, and the field is zero after reset.
- R3: While capture runs, one entry per clock is written from the selected bus at the write position, and the position then advances. A start command resumes at the current write position, after the entries already held.
- R4: With capture stopped, the high data register (address 2) returns entry bits 127:64. The low data register (address 3) returns entry bits 62:0 with bit 63 forced to zero.
- R5: While capture runs, a low data read returns only bit 63 set, a high data read returns zero, and neither read moves a read position.
- R6: A stop command places both read positions at the oldest entry. With capture stopped, each data read steps only its own register's position toward younger entries. After the youngest entry, the position wraps back to the oldest.
- R7: Once the store has filled, the oldest entry is the one just after the most recent write. A stopped dump returns exactly the last DEPTH captures, oldest first.
- R8: A clear command zeroes the write position, the fill flag and both read positions. It leaves stored entries untouched.
- R9: `rdata_o` takes the read value on the clock edge at the end of the strobe cycle and holds it until the next read. It is zero after reset. Reads of addresses 4 to 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Single-cycle register access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Registered read data |
| trace_bus_i | input | 512 | Four 128-bit trace buses, bus k at bits k*128+127 down to k*128 |

## Verification
The bench drives the trace buses with a cycle stamp and a bus tag, so every stored entry shows where and when it was captured. It attacks these corners:
- **Wrap point of a filled store.** An off-by-one in the oldest-entry computation would start the dump one entry early or late.
- **Resumed capture.** A write position that restarted at zero would overwrite the earlier entries.
- **Independent high and low positions.** Shared positions would make the high pass start mid-trace.
- **Clear with data left in the store.** A fill flag that survived the clear would make the dump begin at stale entries.
- **Start and stop in the same write.** The wrong priority would leave capture running.
- **Reads while running.** These must return only the flag and must not leak entry data.

// File: rtl/trace_buf_pkg.sv
package trace_buf_pkg;
  localparam int DATA_W  = 64;
  localparam int ENTRY_W = 2 * DATA_W;
  localparam int NUM_BUS = 4;
  localparam int SEL_W   = $clog2(NUM_BUS);
  localparam int REG_AW  = 3;

  localparam logic [REG_AW-1:0] REG_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] REG_CFG  = 3'd1;
  localparam logic [REG_AW-1:0] REG_HI   = 3'd2;
  localparam logic [REG_AW-1:0] REG_LO   = 3'd3;

  // word bit n counted from the MSB sits at vector index DATA_W-1-n
  localparam int CMD_START_BIT = DATA_W - 1 - 0;
  localparam int CMD_STOP_BIT  = DATA_W - 1 - 1;
  localparam int CMD_CLR_BIT   = DATA_W - 1 - 2;
  localparam int SEL_LSB       = DATA_W - 1 - 15;
  localparam int RUN_BIT       = DATA_W - 1;

  typedef struct packed {
    logic start;
    logic stop;
    logic clr;
  } trace_cmd_t;
endpackage

// File: rtl/trace_buf_sel.sv
module trace_buf_sel
  import trace_buf_pkg::*;
(
  input  logic [NUM_BUS*ENTRY_W-1:0] bus_i,
  input  logic [SEL_W-1:0]           sel_i,
  output logic [ENTRY_W-1:0]         entry_o
);
  logic [ENTRY_W-1:0] lane [NUM_BUS];

  for (genvar g = 0; g < NUM_BUS; g++) begin : g_lane
    assign lane[g] = bus_i[g*ENTRY_W +: ENTRY_W];
  end

  assign entry_o = lane[sel_i];
endmodule

// File: rtl/trace_buf_store.sv
module trace_buf_store
  import trace_buf_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic               wr_en_i,
  input  logic [AW-1:0]      wr_addr_i,
  input  logic [ENTRY_W-1:0] wr_data_i,
  input  logic [AW-1:0]      hi_addr_i,
  input  logic [AW-1:0]      lo_addr_i,
  output logic [DATA_W-1:0]  hi_data_o,
  output logic [DATA_W-1:0]  lo_data_o
);
  logic [ENTRY_W-1:0] mem_q [DEPTH];

  // contents are not reset: a clear must leave old entries in place
  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  assign hi_data_o = mem_q[hi_addr_i][ENTRY_W-1:DATA_W];
  assign lo_data_o = mem_q[lo_addr_i][DATA_W-1:0];
endmodule

// File: rtl/trace_buf_ptrs.sv
module trace_buf_ptrs
  import trace_buf_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  trace_cmd_t    cmd_i,
  input  logic          hi_step_i,
  input  logic          lo_step_i,
  output logic          running_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_ptr_o,
  output logic [AW-1:0] hi_ptr_o,
  output logic [AW-1:0] lo_ptr_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  function automatic logic [AW-1:0] step_f(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  logic          running_q, running_d;
  logic          wrapped_q, wrapped_d;
  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] hi_ptr_q, hi_ptr_d;
  logic [AW-1:0] lo_ptr_q, lo_ptr_d;
  logic [AW-1:0] oldest;
  logic          wr_en;

  always_comb begin
    wr_en     = running_q && !cmd_i.clr;
    running_d = cmd_i.stop ? 1'b0 : (cmd_i.start ? 1'b1 : running_q);
    wr_ptr_d  = wr_ptr_q;
    wrapped_d = wrapped_q;
    if (cmd_i.clr) begin
      wr_ptr_d  = '0;
      wrapped_d = 1'b0;
    end else if (wr_en) begin
      wr_ptr_d = step_f(wr_ptr_q);
      if (wr_ptr_q == LAST) wrapped_d = 1'b1;
    end
    // oldest entry after this cycle's write lands
    oldest   = wrapped_d ? wr_ptr_d : '0;
    hi_ptr_d = hi_ptr_q;
    lo_ptr_d = lo_ptr_q;
    if (cmd_i.clr) begin
      hi_ptr_d = '0;
      lo_ptr_d = '0;
    end else if (cmd_i.stop) begin
      hi_ptr_d = oldest;
      lo_ptr_d = oldest;
    end else begin
      if (hi_step_i) hi_ptr_d = step_f(hi_ptr_q);
      if (lo_step_i) lo_ptr_d = step_f(lo_ptr_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
      wrapped_q <= 1'b0;
      wr_ptr_q  <= '0;
      hi_ptr_q  <= '0;
      lo_ptr_q  <= '0;
    end else begin
      running_q <= running_d;
      wrapped_q <= wrapped_d;
      wr_ptr_q  <= wr_ptr_d;
      hi_ptr_q  <= hi_ptr_d;
      lo_ptr_q  <= lo_ptr_d;
    end
  end

  assign running_o = running_q;
  assign wr_en_o   = wr_en;
  assign wr_ptr_o  = wr_ptr_q;
  assign hi_ptr_o  = hi_ptr_q;
  assign lo_ptr_o  = lo_ptr_q;

  // R1
  stop_halts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.stop |=> !running_q);
  // R1
  start_runs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.start && !cmd_i.stop) |=> running_q);
  // R3
  wr_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_q && !cmd_i.clr) |=> wr_ptr_q == step_f($past(wr_ptr_q)));
  // R5
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_q && !cmd_i.stop && !cmd_i.clr) |=> ($stable(hi_ptr_q) && $stable(lo_ptr_q)));
  // R6
  stop_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.stop |=> hi_ptr_q == lo_ptr_q);
  // R8
  clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.clr |=> (wr_ptr_q == '0 && !wrapped_q && hi_ptr_q == '0 && lo_ptr_q == '0));
endmodule

// File: rtl/trace_buf.sv
module trace_buf
  import trace_buf_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic                       we_i,
  input  logic [REG_AW-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          rdata_o,
  input  logic [NUM_BUS*ENTRY_W-1:0] trace_bus_i
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [DATA_W-1:0] RUN_WORD = DATA_W'(1) << RUN_BIT;

  logic              wr_acc, rd_acc;
  trace_cmd_t        cmd;
  logic [SEL_W-1:0]  sel_q;
  logic              running, wr_en, hi_step, lo_step;
  logic [AW-1:0]     wr_ptr, hi_ptr, lo_ptr;
  logic [ENTRY_W-1:0] cap_entry;
  logic [DATA_W-1:0] hi_raw, lo_raw, rdata_d, rdata_q;
  logic              unused_bits;

  assign wr_acc    = req_i && we_i;
  assign rd_acc    = req_i && !we_i;
  assign cmd.start = wr_acc && addr_i == REG_CTRL && wdata_i[CMD_START_BIT];
  assign cmd.stop  = wr_acc && addr_i == REG_CTRL && wdata_i[CMD_STOP_BIT];
  assign cmd.clr   = wr_acc && addr_i == REG_CTRL && wdata_i[CMD_CLR_BIT];
  assign hi_step   = rd_acc && addr_i == REG_HI && !running;
  assign lo_step   = rd_acc && addr_i == REG_LO && !running;
  assign unused_bits = ^{wdata_i[CMD_CLR_BIT-1:SEL_LSB+SEL_W], wdata_i[SEL_LSB-1:0], lo_raw[RUN_BIT]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else if (wr_acc && addr_i == REG_CFG) sel_q <= wdata_i[SEL_LSB +: SEL_W];
  end

  trace_buf_sel u_sel (
    .bus_i   (trace_bus_i),
    .sel_i   (sel_q),
    .entry_o (cap_entry)
  );

  trace_buf_ptrs #(.DEPTH(DEPTH), .AW(AW)) u_ptrs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (cmd),
    .hi_step_i (hi_step),
    .lo_step_i (lo_step),
    .running_o (running),
    .wr_en_o   (wr_en),
    .wr_ptr_o  (wr_ptr),
    .hi_ptr_o  (hi_ptr),
    .lo_ptr_o  (lo_ptr)
  );

  trace_buf_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_ptr),
    .wr_data_i (cap_entry),
    .hi_addr_i (hi_ptr),
    .lo_addr_i (lo_ptr),
    .hi_data_o (hi_raw),
    .lo_data_o (lo_raw)
  );

  always_comb begin
    rdata_d = '0;
    unique case (addr_i)
      REG_CFG: rdata_d[SEL_LSB +: SEL_W] = sel_q;
      REG_HI:  rdata_d = running ? '0 : hi_raw;
      // flag bit is reserved: never carries entry data
      REG_LO:  rdata_d = running ? RUN_WORD : {1'b0, lo_raw[RUN_BIT-1:0]};
      default: rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd_acc) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;

  // R2
  cfg_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc && addr_i == REG_CFG) |=> sel_q == $past(wdata_i[SEL_LSB +: SEL_W]));
  // R9
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && addr_i > REG_LO) |=> rdata_o == '0);
  // R9
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_acc |=> $stable(rdata_o));
  // R5
  run_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && addr_i == REG_LO && running) |=> rdata_o == RUN_WORD);
endmodule

// File: tb/trace_buf_tb.sv
`timescale 1ns/1ps
module trace_buf_tb;
  localparam int D = 16;
  localparam logic [63:0] C_START = 64'h8000_0000_0000_0000;
  localparam logic [63:0] C_STOP  = 64'h4000_0000_0000_0000;
  localparam logic [63:0] C_CLR   = 64'h2000_0000_0000_0000;
  localparam logic [63:0] FLAG    = 64'h8000_0000_0000_0000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req = 1'b0, we = 1'b0;
  logic [2:0]   addr = '0;
  logic [63:0]  wdata = '0;
  logic [63:0]  rdata;
  logic [511:0] bus;
  logic [63:0]  cyc;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= '0;
    else cyc <= cyc + 64'd1;
  end

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      logic [63:0] t;
      t = cyc + 64'd1000;
      bus[k*128 +: 128] = {8'(8'hA0 + k), cyc[55:0], 8'(8'hC0 + k), t[55:0]};
    end
  end

  trace_buf #(.DEPTH(D)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .trace_bus_i(bus)
  );

  function automatic logic [63:0] exp_hi(int k, logic [63:0] s);
    return {8'(8'hA0 + k), s[55:0]};
  endfunction

  function automatic logic [63:0] exp_lo(int k, logic [63:0] s);
    logic [63:0] t;
    t = s + 64'd1000;
    return {8'(8'h40 + k), t[55:0]};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [63:0] d, output logic [63:0] stamp);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; stamp = cyc;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [63:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic set_sel(int k);
    logic [63:0] s;
    reg_wr(3'd1, 64'(k) << 48, s);
  endtask

  logic [63:0] s1, n1, a2, n2, b3, a4, n4;

  task automatic t_reset();
    logic [63:0] d;
    chk("R9 rdata after reset", rdata, 64'd0);
    reg_rd(3'd1, d);
    chk("R2 select after reset", d, 64'd0);
  endtask

  task automatic t_cfg();
    logic [63:0] d, s;
    reg_wr(3'd1, '1, s);
    reg_rd(3'd1, d);
    chk("R2 field only", d, 64'h0003_0000_0000_0000);
    reg_wr(3'd1, 64'd0, s);
    chk("R9 hold across write", rdata, 64'h0003_0000_0000_0000);
    reg_rd(3'd0, d);
    chk("R1 command reads zero", d, 64'd0);
    reg_rd(3'd7, d);
    chk("R9 unmapped 7", d, 64'd0);
    reg_rd(3'd4, d);
    chk("R9 unmapped 4", d, 64'd0);
  endtask

  task automatic t_short();
    logic [63:0] d, a, b;
    set_sel(1);
    reg_wr(3'd0, C_START, a);
    reg_rd(3'd3, d);
    chk("R5 low while running", d, FLAG);
    reg_rd(3'd2, d);
    chk("R5 high while running", d, 64'd0);
    reg_wr(3'd0, C_STOP, b);
    n1 = b - a; s1 = a + 64'd1;
    for (int i = 0; i < int'(n1); i++) begin
      reg_rd(3'd3, d);
      chk("R4/R6 low walk", d, exp_lo(1, s1 + 64'(i)));
    end
    for (int i = 0; i < int'(n1); i++) begin
      reg_rd(3'd2, d);
      chk("R4/R6 high walk", d, exp_hi(1, s1 + 64'(i)));
    end
  endtask

  task automatic t_resume();
    logic [63:0] d, b;
    set_sel(2);
    reg_wr(3'd0, C_START, a2);
    repeat (3) @(negedge clk);
    reg_wr(3'd0, C_STOP, b);
    n2 = b - a2;
    for (int i = 0; i < int'(n1 + n2); i++) begin
      reg_rd(3'd3, d);
      if (i < int'(n1)) chk("R3 resume keeps old", d, exp_lo(1, s1 + 64'(i)));
      else chk("R3 resume appends R2 bus", d, exp_lo(2, a2 + 64'd1 + 64'(i - int'(n1))));
    end
  endtask

  task automatic t_wrap();
    logic [63:0] d, a, first;
    set_sel(3);
    reg_wr(3'd0, C_START, a);
    repeat (30) @(negedge clk);
    reg_wr(3'd0, C_STOP, b3);
    first = b3 - 64'(D) + 64'd1;
    reg_rd(3'd2, d);
    chk("R7 high oldest", d, exp_hi(3, first));
    for (int i = 0; i < D; i++) begin
      reg_rd(3'd3, d);
      chk("R7 low last D", d, exp_lo(3, first + 64'(i)));
    end
    reg_rd(3'd3, d);
    chk("R6 wrap to oldest", d, exp_lo(3, first));
  endtask

  task automatic t_clear();
    logic [63:0] d, s, b;
    reg_wr(3'd0, C_CLR, s);
    reg_wr(3'd0, C_START, a4);
    reg_wr(3'd0, C_STOP, b);
    n4 = b - a4;
    for (int i = 0; i < int'(n4); i++) begin
      reg_rd(3'd3, d);
      chk("R8 fresh from slot 0", d, exp_lo(3, a4 + 64'd1 + 64'(i)));
    end
    reg_rd(3'd3, d);
    chk("R8 old entry kept", {56'd0, d[63:56]}, 64'h43);
  endtask

  task automatic t_both();
    logic [63:0] d, s;
    reg_wr(3'd0, C_START | C_STOP, s);
    reg_rd(3'd3, d);
    chk("R1 stop wins over start", d, exp_lo(3, a4 + 64'd1));
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_short();
    t_resume();
    t_wrap();
    t_clear();
    t_both();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end
endmodule